// File: doc/BRIEF.md
# Status and Mask Interrupt Controller

This block collects interrupt source pulses into three pending registers and drives three interrupt lines toward a processor. A main status register is paired with a separate main mask register. A packed DMA word holds sixteen channel status bits in its low half and sixteen channel mask bits in its high half. A flag register for a secondary bus has no mask. Software clears pending bits by writing ones to them.

Every register sits on a simple word-wide write port with a combinational read path. Each interrupt line is a flop. The flop loads from the register values that the same clock edge is about to store, so a write or a source pulse shows on the line in the cycle that follows the edge. Priority encoding, vectoring and acknowledge handshakes are left to the interrupt logic upstream.

Top module: `intc_stat_mask`

## Requirements
- R1: After reset every status, mask and flag register reads as zero and `main_irq`, `dma_irq` and `sbus_irq` are low.
- R2: A high bit on `main_src`, `dma_src` or `sbus_src` during a clock edge sets the matching bit of the main status register, of the DMA status half or of the secondary-bus flag register. The bit stays set until it is cleared.
- R3: A write to address 0xF000 clears every main status bit whose write-data bit is 1 and leaves the other bits as they were.
- R4: When a source pulse and a clearing write hit the same bit in the same cycle, the bit ends up set. This holds for all three pending registers.
- R5: A write to address 0xF010 loads the main mask, and a read returns it. `main_irq` is high exactly when main status AND main mask is nonzero. It follows a change in the cycle after the clocking edge.
- R6: A read of address 0xE010 returns the DMA mask in bits [31:16] and the DMA status in bits [15:0]. A write clears each status bit whose bit in wdata[15:0] is 1.
- R7: A write to 0xE010 toggles each DMA mask bit whose bit in wdata[31:16] is 1. Mask bits with a 0 in the write data stay unchanged.
- R8: `dma_irq` is high exactly when DMA status AND DMA mask is nonzero. It is updated in the cycle after the edge.
- R9: Address 0xF230 is the secondary-bus flag register. A write clears each flag whose write-data bit is 1. `sbus_irq` is high while any flag is set and drops only when all flags are zero.
- R10: A write to any other address changes no register. A read of any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 16 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| main_src | input | MAIN_W | Main interrupt source pulses |
| dma_src | input | 16 | DMA channel source pulses |
| sbus_src | input | SBUS_W | Secondary-bus source pulses |
| main_irq | output | 1 | Main interrupt request |
| dma_irq | output | 1 | DMA interrupt request |
| sbus_irq | output | 1 | Secondary-bus interrupt request |

## Verification
The properties assume that `wr_en`, `addr`, `wdata` and the source vectors are steady around the rising edge. They also assume that a clear only brings a line low when no source pulses in that same cycle. The bench drives every input on the falling edge. It holds the sources at zero during clearing writes, except in the scenarios that test set-over-clear on purpose. Results are sampled on the falling edge, half a cycle after the edge that updates the registers and lines.

// File: rtl/intc_stat_mask.sv
module intc_stat_mask #(
  parameter int MAIN_W = 32,
  parameter int SBUS_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [MAIN_W-1:0] main_src,
  input  logic [15:0]       dma_src,
  input  logic [SBUS_W-1:0] sbus_src,
  output logic              main_irq,
  output logic              dma_irq,
  output logic              sbus_irq
);
  localparam logic [15:0] A_MSTAT = 16'hF000;
  localparam logic [15:0] A_MMASK = 16'hF010;
  localparam logic [15:0] A_DMA   = 16'hE010;
  localparam logic [15:0] A_SBUS  = 16'hF230;

  logic [MAIN_W-1:0] main_stat, main_mask, main_stat_nx, main_mask_nx;
  logic [15:0]       dma_stat, dma_mask, dma_stat_nx, dma_mask_nx;
  logic [SBUS_W-1:0] sbus_flag, sbus_flag_nx;

  wire wr_mstat = wr_en && addr == A_MSTAT;
  wire wr_mmask = wr_en && addr == A_MMASK;
  wire wr_dma   = wr_en && addr == A_DMA;
  wire wr_sbus  = wr_en && addr == A_SBUS;

  assign main_stat_nx = (main_stat & ~(wr_mstat ? wdata[MAIN_W-1:0] : '0)) | main_src;
  assign main_mask_nx = wr_mmask ? wdata[MAIN_W-1:0] : main_mask;
  assign dma_stat_nx  = (dma_stat & ~(wr_dma ? wdata[15:0] : 16'h0)) | dma_src;
  assign dma_mask_nx  = dma_mask ^ (wr_dma ? wdata[31:16] : 16'h0);
  assign sbus_flag_nx = (sbus_flag & ~(wr_sbus ? wdata[SBUS_W-1:0] : '0)) | sbus_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_stat <= '0;
      main_mask <= '0;
      dma_stat  <= '0;
      dma_mask  <= '0;
      sbus_flag <= '0;
      main_irq  <= 1'b0;
      dma_irq   <= 1'b0;
      sbus_irq  <= 1'b0;
    end else begin
      main_stat <= main_stat_nx;
      main_mask <= main_mask_nx;
      dma_stat  <= dma_stat_nx;
      dma_mask  <= dma_mask_nx;
      sbus_flag <= sbus_flag_nx;
      main_irq  <= |(main_stat_nx & main_mask_nx);
      dma_irq   <= |(dma_stat_nx & dma_mask_nx);
      sbus_irq  <= |sbus_flag_nx;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_MSTAT: rdata[MAIN_W-1:0] = main_stat;
      A_MMASK: rdata[MAIN_W-1:0] = main_mask;
      A_DMA:   rdata = {dma_mask, dma_stat};
      A_SBUS:  rdata[SBUS_W-1:0] = sbus_flag;
      default: rdata = '0;
    endcase
  end
endmodule

module intc_stat_mask_chk #(
  parameter int MAIN_W = 32,
  parameter int SBUS_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [15:0]       addr,
  input logic [31:0]       wdata,
  input logic [MAIN_W-1:0] main_src,
  input logic [15:0]       dma_src,
  input logic [SBUS_W-1:0] sbus_src,
  input logic [MAIN_W-1:0] main_stat,
  input logic [15:0]       dma_mask,
  input logic              main_irq,
  input logic              dma_irq,
  input logic              sbus_irq
);
  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|main_src) |=> ((main_stat & $past(main_src)) == $past(main_src)));
  // R5
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 16'hF010 && wdata == 32'h0) |=> !main_irq);
  // R7
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 16'hE010 && wdata[31:16] == 16'h0) |=> $stable(dma_mask));
  // R8
  dma_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 16'hE010 && wdata[15:0] == 16'hFFFF && dma_src == 16'h0) |=> !dma_irq);
  // R9
  sbus_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 16'hF230 && wdata == 32'hFFFF_FFFF && sbus_src == '0) |=> !sbus_irq);
  // R9
  sbus_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|sbus_src) |=> sbus_irq);
endmodule

bind intc_stat_mask intc_stat_mask_chk #(.MAIN_W(MAIN_W), .SBUS_W(SBUS_W)) chk_i (.*);

// File: tb/intc_stat_mask_tb_top.sv
module intc_stat_mask_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0, rdata, main_src = '0, sbus_src = '0;
  logic [15:0] dma_src = '0;
  logic main_irq, dma_irq, sbus_irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  intc_stat_mask dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .main_src(main_src), .dma_src(dma_src),
    .sbus_src(sbus_src), .main_irq(main_irq), .dma_irq(dma_irq), .sbus_irq(sbus_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(16'hF000, v); chk("R1 mstat", v, 0);
    rd(16'hF010, v); chk("R1 mmask", v, 0);
    rd(16'hE010, v); chk("R1 dma", v, 0);
    rd(16'hF230, v); chk("R1 sbus", v, 0);
    chk("R1 irqs", {main_irq, dma_irq, sbus_irq}, 0);
  endtask

  task automatic t_main;
    logic [31:0] v;
    main_src = 32'h0000_00A5; @(negedge clk); main_src = '0;
    rd(16'hF000, v); chk("R2 main set", v, 32'hA5);
    chk("R5 masked off", main_irq, 0);
    wr(16'hF010, 32'h0000_0004);
    rd(16'hF010, v); chk("R5 mask read", v, 32'h4);
    chk("R5 irq up", main_irq, 1);
    wr(16'hF000, 32'h0000_0021);
    rd(16'hF000, v); chk("R3 clear", v, 32'h84);
    chk("R5 irq held", main_irq, 1);
    wr(16'hF000, 32'h0000_0004);
    chk("R5 irq drop", main_irq, 0);
    main_src = 32'h0000_0080; addr = 16'hF000; wdata = 32'h80; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; main_src = '0;
    rd(16'hF000, v); chk("R4 main set wins", v, 32'h80);
  endtask

  task automatic t_dma;
    logic [31:0] v;
    dma_src = 16'h0103; @(negedge clk); dma_src = '0;
    rd(16'hE010, v); chk("R2 dma set", v, 32'h0000_0103);
    chk("R8 masked", dma_irq, 0);
    wr(16'hE010, 32'h0102_0000);
    rd(16'hE010, v); chk("R7 toggle on", v, 32'h0102_0103);
    chk("R8 irq up", dma_irq, 1);
    wr(16'hE010, 32'h0000_0001);
    rd(16'hE010, v); chk("R6 clear keeps mask", v, 32'h0102_0102);
    wr(16'hE010, 32'h0100_0100);
    rd(16'hE010, v); chk("R7 toggle off", v, 32'h0002_0002);
    chk("R8 irq still", dma_irq, 1);
    wr(16'hE010, 32'h0000_0002);
    chk("R8 irq drop", dma_irq, 0);
    dma_src = 16'h0040; addr = 16'hE010; wdata = 32'h40; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; dma_src = '0;
    rd(16'hE010, v); chk("R4 dma set wins", v, 32'h0002_0040);
    wr(16'hE010, 32'h0000_FFFF);
  endtask

  task automatic t_sbus;
    logic [31:0] v;
    sbus_src = 32'h8000_0001; @(negedge clk); sbus_src = '0;
    chk("R9 irq up", sbus_irq, 1);
    wr(16'hF230, 32'h0000_0001);
    rd(16'hF230, v); chk("R9 partial", v, 32'h8000_0000);
    chk("R9 irq held", sbus_irq, 1);
    wr(16'hF230, 32'h8000_0000);
    chk("R9 irq drop", sbus_irq, 0);
    sbus_src = 32'h10; addr = 16'hF230; wdata = 32'h10; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; sbus_src = '0;
    rd(16'hF230, v); chk("R4 sbus set wins", v, 32'h10);
    wr(16'hF230, 32'hFFFF_FFFF);
  endtask

  task automatic t_other;
    logic [31:0] v;
    wr(16'hF010, 32'h1);
    main_src = 32'h1; @(negedge clk); main_src = '0;
    wr(16'hF004, 32'hFFFF_FFFF);
    wr(16'hE000, 32'hFFFF_FFFF);
    rd(16'hF004, v); chk("R10 read zero", v, 0);
    rd(16'hF000, v); chk("R10 stat kept", v, 32'h81);
    rd(16'hF010, v); chk("R10 mask kept", v, 32'h1);
    rd(16'hE010, v); chk("R10 dma kept", v, 32'h0002_0000);
    chk("R10 irq kept", main_irq, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_main; t_dma; t_sbus; t_other;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule